// File: doc/BRIEF.md
# NAND Single-Bit Hamming ECC Engine

This block protects one chunk of NAND page data (512 bytes by default) with a Hamming code that corrects one bit. Bytes stream in one per accepted cycle. For every one of the 12 bit-address lines of the 4096 bit positions, the engine keeps two even parities: one over the positions whose address bit is 1 and one over the positions whose address bit is 0. The first set forms the upper 12 bits of the code and the second set forms the lower 12 bits. The packed 24-bit value is inverted at the output. As a result, an erased chunk (all 0xFF) produces 0xFFFFFF, which matches erased spare-area bytes.

Once the last byte of the chunk is in, the engine compares its code with the 3 stored ECC bytes and decodes the difference (the syndrome). It reports one of four outcomes:
- the data is clean;
- a single data bit is wrong, given as a byte offset and a one-hot bit mask that the caller applies to its own buffer;
- only the stored code is damaged;
- the chunk cannot be corrected.

A start strobe opens a new chunk. Acknowledging a finished result also clears the engine so that the next calculation can begin.

Top module: `hecc_engine`

## Requirements
- R1: After reset, `done` is 0, `calcEcc` is 0xFFFFFF, `status` is 0 and `errMask` is 0.
- R2: `startIn` synchronously clears the parities, the byte count and `done`. A byte presented in the same cycle as `startIn` is ignored, so the next accepted byte is byte 0.
- R3: `done` rises in the cycle after the 512th accepted byte. While `done` is high, further bytes are ignored and `calcEcc` holds.
- R4: The bit at position p = 8·offset + bit (bit 0 = LSB of the byte) toggles code bit 12+k when p[k]=1 and code bit k when p[k]=0. `calcEcc` is the inverse of this parity vector. `calcEcc[7:0]` is the first ECC byte and `calcEcc[23:16]` is the last. `storedEcc` uses the same byte order.
- R5: A chunk of all 0xFF bytes yields `calcEcc` = 0xFFFFFF.
- R6: With `done` high and syndrome `calcEcc ^ storedEcc` equal to zero, `status` is 0 (clean) and `errMask` is 0.
- R7: When the syndrome's upper and lower 12 bits XOR to 0xFFF, `status` is 1 and `errOffset` is syndrome[23:15]. `errMask` is one-hot at bit index syndrome[14:12].
- R8: A syndrome with exactly one bit set gives `status` 2 (stored code damaged, data intact) and `errMask` 0.
- R9: Any other nonzero syndrome, for example two flipped data bits, gives `status` 3 (uncorrectable) and `errMask` 0.
- R10: `ackIn` while `done` is high clears the engine in one cycle, so `done` drops and `calcEcc` returns to 0xFFFFFF. `ackIn` while `done` is low has no effect on the chunk in progress.
- R11: While `done` is low, `status` reads 0 and `errMask` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Begin a new chunk (clears state) |
| byteValid | input | 1 | `byteData` carries the next data byte |
| byteData | input | 8 | Data byte |
| ackIn | input | 1 | Result consumed; clears the engine when `done` |
| storedEcc | input | 24 | ECC bytes read from flash, first byte in bits 7:0 |
| done | output | 1 | Chunk complete, result outputs valid |
| calcEcc | output | 24 | Computed ECC bytes, first byte in bits 7:0 |
| status | output | 2 | 0 clean, 1 data bit fixable, 2 code-only error, 3 uncorrectable |
| errOffset | output | 9 | Byte offset of the faulty data bit |
| errMask | output | 8 | One-hot mask to XOR into that byte |

## Verification
The bench flips the extreme bit positions 0 and 4095. A design with swapped halves, a reversed offset or a wrong byte order would report the wrong offset or mask there. It damages one stored code bit and checks that the data mask stays zero; a decoder that tests the complement rule incorrectly would flip a good data bit. It flips two data bits and expects uncorrectable, because a weak decoder could misread that syndrome as a single-bit fix. It also sends bytes after completion, acknowledges mid-chunk and restarts mid-chunk with a byte present. An engine that kept counting, cleared early or took the strobe-cycle byte would then produce a code different from the one the bench model computes.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_DATA_FIX = 2'd1,
    ST_CODE_FIX = 2'd2,
    ST_BAD      = 2'd3
  } eccStatus_t;

  typedef struct packed {
    logic clear;
    logic accept;
  } ctrlStrobe_t;

  // Bits of a byte whose in-byte bit index has address bit k set.
  function automatic logic [7:0] laneMask(int k);
    logic [7:0] m;
    for (int j = 0; j < 8; j++) m[j] = (((j >> k) & 1) == 1);
    return m;
  endfunction

endpackage

// File: rtl/hecc_ctrl.sv
module hecc_ctrl
  import hecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  localparam int OFFW = $clog2(CHUNK_BYTES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startIn,
  input  logic            byteValid,
  input  logic            ackIn,
  output ctrlStrobe_t     strobe,
  output logic [OFFW-1:0] byteIdx,
  output logic            done
);

  localparam logic [OFFW-1:0] LAST  = OFFW'(CHUNK_BYTES - 1);
  localparam logic [OFFW:0]   LIMIT = (OFFW + 1)'(CHUNK_BYTES);

  logic [OFFW-1:0] cnt;
  logic            doneQ;

  always_comb begin
    strobe.clear  = startIn | (ackIn & doneQ);
    strobe.accept = byteValid & ~doneQ & ~startIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      doneQ <= 1'b0;
    end else if (strobe.clear) begin
      cnt   <= '0;
      doneQ <= 1'b0;
    end else if (strobe.accept) begin
      if (cnt == LAST) begin
        cnt   <= '0;
        doneQ <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign byteIdx = cnt;
  assign done    = doneQ;

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> (!done && byteIdx == '0));

  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startIn && !ackIn) |=> done);

  a_r10_ack_drops: assert property (@(posedge clk) disable iff (!rstN)
    (done && ackIn) |=> !done);

  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, byteIdx} < LIMIT));

endmodule

// File: rtl/hecc_datapath.sv
module hecc_datapath
  import hecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  localparam int OFFW  = $clog2(CHUNK_BYTES),
  localparam int ADDRW = OFFW + 3,
  localparam int CODEW = 2 * ADDRW
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [OFFW-1:0]  byteIdx,
  input  logic [7:0]       byteData,
  input  logic             done,
  input  logic [CODEW-1:0] storedEcc,
  output logic [CODEW-1:0] calcEcc,
  output eccStatus_t       status,
  output logic [OFFW-1:0]  errOffset,
  output logic [7:0]       errMask
);

  localparam logic [OFFW:0] LIMIT = (OFFW + 1)'(CHUNK_BYTES);

  logic [ADDRW-1:0] onesPar, zerosPar;
  logic [ADDRW-1:0] onesHit, zerosHit;
  logic             bytePar;

  assign bytePar = ^byteData;

  // In-byte address bits: parity of the lanes selected by each mask.
  for (genvar k = 0; k < 3; k++) begin : g_lane
    localparam logic [7:0] M = laneMask(k);
    assign onesHit[k]  = ^(byteData & M);
    assign zerosHit[k] = ^(byteData & ~M);
  end

  // Byte-offset address bits: whole-byte parity steered by the offset bit.
  for (genvar k = 3; k < ADDRW; k++) begin : g_off
    assign onesHit[k]  = byteIdx[k-3] & bytePar;
    assign zerosHit[k] = ~byteIdx[k-3] & bytePar;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesPar  <= '0;
      zerosPar <= '0;
    end else if (strobe.clear) begin
      onesPar  <= '0;
      zerosPar <= '0;
    end else if (strobe.accept) begin
      onesPar  <= onesPar ^ onesHit;
      zerosPar <= zerosPar ^ zerosHit;
    end
  end

  assign calcEcc = ~{onesPar, zerosPar};

  logic [CODEW-1:0] syn;
  logic [ADDRW-1:0] synHi, synLo;
  logic [OFFW-1:0]  offRaw;
  logic [2:0]       bitRaw;

  assign syn    = calcEcc ^ storedEcc;
  assign synHi  = syn[CODEW-1:ADDRW];
  assign synLo  = syn[ADDRW-1:0];
  assign offRaw = synHi[ADDRW-1:3];
  assign bitRaw = synHi[2:0];

  always_comb begin
    status    = ST_CLEAN;
    errOffset = '0;
    errMask   = '0;
    if (done && syn != '0) begin
      if ((synHi ^ synLo) == '1) begin
        if ({1'b0, offRaw} < LIMIT) begin
          status    = ST_DATA_FIX;
          errOffset = offRaw;
          errMask   = 8'b1 << bitRaw;
        end else begin
          status = ST_BAD;
        end
      end else if ($onehot(syn)) begin
        status = ST_CODE_FIX;
      end else begin
        status = ST_BAD;
      end
    end
  end

  a_r7_mask_onehot: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_DATA_FIX) |-> ($countones(errMask) == 1));

  a_r9_no_mask_otherwise: assert property (@(posedge clk) disable iff (!rstN)
    (status != ST_DATA_FIX) |-> (errMask == 8'h00));

  a_r11_idle_clean: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (status == ST_CLEAN));

  a_r2_clear_erases: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (calcEcc == '1));

  a_r3_code_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (done && !strobe.clear) |=> $stable(calcEcc));

endmodule

// File: rtl/hecc_engine.sv
module hecc_engine
  import hecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 512,
  localparam int OFFW  = $clog2(CHUNK_BYTES),
  localparam int CODEW = 2 * (OFFW + 3)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             byteValid,
  input  logic [7:0]       byteData,
  input  logic             ackIn,
  input  logic [CODEW-1:0] storedEcc,
  output logic             done,
  output logic [CODEW-1:0] calcEcc,
  output logic [1:0]       status,
  output logic [OFFW-1:0]  errOffset,
  output logic [7:0]       errMask
);

  ctrlStrobe_t     strobe;
  logic [OFFW-1:0] byteIdx;
  eccStatus_t      statusInt;

  hecc_ctrl #(.CHUNK_BYTES(CHUNK_BYTES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .byteValid (byteValid),
    .ackIn     (ackIn),
    .strobe    (strobe),
    .byteIdx   (byteIdx),
    .done      (done)
  );

  hecc_datapath #(.CHUNK_BYTES(CHUNK_BYTES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .byteIdx   (byteIdx),
    .byteData  (byteData),
    .done      (done),
    .storedEcc (storedEcc),
    .calcEcc   (calcEcc),
    .status    (statusInt),
    .errOffset (errOffset),
    .errMask   (errMask)
  );

  assign status = statusInt;

endmodule

// File: tb/tb_hecc_engine.sv
module tb_hecc_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic        ackIn = 1'b0;
  logic [23:0] storedEcc = 24'hFFFFFF;
  logic        done;
  logic [23:0] calcEcc;
  logic [1:0]  status;
  logic [8:0]  errOffset;
  logic [7:0]  errMask;

  int checks = 0;
  int failures = 0;
  logic [7:0] chunk [512];

  always #5 clk = ~clk;

  hecc_engine dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .byteValid(byteValid),
    .byteData(byteData), .ackIn(ackIn), .storedEcc(storedEcc),
    .done(done), .calcEcc(calcEcc), .status(status),
    .errOffset(errOffset), .errMask(errMask)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  // Model from R4: XOR of positions of set bits, and of their complements.
  function automatic logic [23:0] refEcc();
    logic [11:0] ones;
    logic [11:0] zeros;
    ones = '0;
    zeros = '0;
    for (int i = 0; i < 512; i++)
      for (int j = 0; j < 8; j++)
        if (chunk[i][j]) begin
          ones  = ones ^ 12'(i * 8 + j);
          zeros = zeros ^ ~12'(i * 8 + j);
        end
    return ~{ones, zeros};
  endfunction

  task automatic feed(input int first, input int count);
    for (int i = first; i < first + count; i++) begin
      @(negedge clk);
      if ($urandom % 6 == 0) begin
        byteValid = 1'b0;
        @(negedge clk);
      end
      byteValid = 1'b1;
      byteData  = chunk[i];
    end
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic startChunk(input bit withByte);
    @(negedge clk);
    startIn   = 1'b1;
    byteValid = withByte;
    byteData  = 8'h5A;
    @(negedge clk);
    startIn   = 1'b0;
    byteValid = 1'b0;
  endtask

  task automatic fillRandom();
    for (int i = 0; i < 512; i++) chunk[i] = 8'($urandom);
  endtask

  task automatic flip(input int p);
    chunk[p >> 3] = chunk[p >> 3] ^ (8'h01 << (p & 7));
  endtask

  task automatic runDataFlip(input int p, input string tag);
    logic [23:0] good;
    fillRandom();
    good = refEcc();
    flip(p);
    storedEcc = good;
    startChunk(1'b0);
    feed(0, 512);
    chkEq({tag, " status"}, 32'(status), 32'd1);
    chkEq({tag, " offset"}, 32'(errOffset), 32'(p >> 3));
    chkEq({tag, " mask"}, 32'(errMask), 32'(8'h01 << (p & 7)));
  endtask

  initial begin
    int unsigned seedDummy;
    logic [23:0] expEcc;
    seedDummy = $urandom(32'd4177);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1 done after reset", 32'(done), 32'd0);
    chkEq("R1 calcEcc after reset", 32'(calcEcc), 32'hFFFFFF);
    chkEq("R1 status after reset", 32'(status), 32'd0);
    chkEq("R1 errMask after reset", 32'(errMask), 32'd0);

    // R5 / R6: erased chunk
    for (int i = 0; i < 512; i++) chunk[i] = 8'hFF;
    storedEcc = 24'hFFFFFF;
    startChunk(1'b0);
    feed(0, 300);
    chkEq("R11 status while busy", 32'(status), 32'd0);
    chkEq("R3 done not early", 32'(done), 32'd0);
    feed(300, 212);
    chkEq("R3 done after last byte", 32'(done), 32'd1);
    chkEq("R5 erased code", 32'(calcEcc), 32'hFFFFFF);
    chkEq("R6 erased clean", 32'(status), 32'd0);

    // R4 directed: only position 0, then only position 4095
    for (int i = 0; i < 512; i++) chunk[i] = 8'h00;
    chunk[0] = 8'h01;
    startChunk(1'b0);
    feed(0, 512);
    chkEq("R4 pos0 code", 32'(calcEcc), 32'hFFF000);
    chkEq("R4 first byte", 32'(calcEcc[7:0]), 32'h00);
    chunk[0] = 8'h00;
    chunk[511] = 8'h80;
    startChunk(1'b0);
    feed(0, 512);
    chkEq("R4 pos4095 code", 32'(calcEcc), 32'h000FFF);

    // Random clean chunks, then stored-code damage on the same result
    for (int n = 0; n < 4; n++) begin
      fillRandom();
      expEcc = refEcc();
      storedEcc = expEcc;
      startChunk(1'b0);
      feed(0, 512);
      chkEq("R4 random code", 32'(calcEcc), 32'(expEcc));
      chkEq("R6 random clean", 32'(status), 32'd0);
      chkEq("R6 random mask", 32'(errMask), 32'd0);
      storedEcc = expEcc ^ (24'h1 << ($urandom % 24));
      #1;
      chkEq("R8 code-only status", 32'(status), 32'd2);
      chkEq("R8 code-only mask", 32'(errMask), 32'd0);
      storedEcc = expEcc ^ 24'h000003;
      #1;
      chkEq("R9 two code bits", 32'(status), 32'd3);
      chkEq("R9 two code bits mask", 32'(errMask), 32'd0);
    end

    // R7 corner and random single data-bit errors
    runDataFlip(0, "R7 pos0");
    runDataFlip(4095, "R7 pos4095");
    for (int n = 0; n < 4; n++) runDataFlip(int'($urandom % 4096), "R7 random");

    // R9: two data bits flipped
    fillRandom();
    storedEcc = refEcc();
    flip(17);
    flip(3000);
    startChunk(1'b0);
    feed(0, 512);
    chkEq("R9 two data bits", 32'(status), 32'd3);
    chkEq("R9 two data bits mask", 32'(errMask), 32'd0);

    // R3: bytes after completion ignored
    fillRandom();
    expEcc = refEcc();
    storedEcc = expEcc;
    startChunk(1'b0);
    feed(0, 512);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      byteValid = 1'b1;
      byteData = 8'h01 << (i & 7);
    end
    @(negedge clk);
    byteValid = 1'b0;
    chkEq("R3 code held after extra bytes", 32'(calcEcc), 32'(expEcc));
    chkEq("R3 done held", 32'(done), 32'd1);

    // R10: ack while done clears
    @(negedge clk);
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
    chkEq("R10 ack drops done", 32'(done), 32'd0);
    chkEq("R10 ack clears code", 32'(calcEcc), 32'hFFFFFF);

    // R10: ack mid-chunk ignored
    fillRandom();
    expEcc = refEcc();
    feed(0, 100);
    @(negedge clk);
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
    feed(100, 412);
    chkEq("R10 mid ack done", 32'(done), 32'd1);
    chkEq("R10 mid ack code", 32'(calcEcc), 32'(expEcc));

    // R2: restart mid-chunk, byte in strobe cycle dropped
    fillRandom();
    expEcc = refEcc();
    feed(0, 200);
    startChunk(1'b1);
    chkEq("R2 start clears code", 32'(calcEcc), 32'hFFFFFF);
    chkEq("R2 start clears done", 32'(done), 32'd0);
    feed(0, 512);
    chkEq("R2 restart code", 32'(calcEcc), 32'(expEcc));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule